// File: doc/BRIEF.md
# Chunked Transmit FIFO Refill Controller

This controller streams a frame held in a local byte buffer into a radio transmit FIFO that is smaller than the frame. A start pulse with a non-zero length begins a frame. The controller first issues an idle strobe and then a flush strobe to the radio. It then writes a large opening burst of up to 63 bytes and fires the transmit strobe. If bytes remain, it tops the FIFO up in bursts of at most 31 bytes while the radio drains it.

Before each top-up the controller reads the radio's FIFO status word. Bits [6:0] hold the fill level and bit 7 flags an underflow. A top-up goes ahead only once the level has fallen to 31 or below, or when the underflow flag is set. Status reads are spaced by a programmable gap. An underflow seen while bytes remain sets a sticky error flag, and the controller still writes the rest of the frame.

The state machine has nine states:
- IDLE waits for an accepted start. IDLE to HALT is taken on start with a non-zero length.
- HALT drives the idle strobe and moves to FLUSH.
- FLUSH drives the flush strobe and moves to HDR.
- HDR announces a burst size and moves to DATA.
- DATA writes one byte per cycle. When the burst ends it goes to FIRE if this is the opening burst, to DONE if the frame is finished, and to WAIT otherwise.
- FIRE drives the transmit strobe. It goes to DONE if nothing remains and to WAIT otherwise.
- WAIT counts out the poll gap and then goes to POLL.
- POLL reads the status word. It goes to HDR to refill, or back to WAIT.
- DONE pulses the done output and returns to IDLE.

Top module: `tx_refill_ctrl`

## Requirements
- R1: After reset, busy_o, done_o, err_o, wr_valid_o, stat_rd_o and all three strobes are low.
- R2: An accepted start gives strobe_idle_o for one cycle. strobe_flush_o follows in the next cycle, and the first burst_start_o comes in the cycle after that.
- R3: A frame of 63 bytes or fewer is written as a single burst of frame_len_i bytes, read from buffer addresses 0 upward in order. strobe_tx_o comes in the cycle after the last byte, and no status read occurs.
- R4: A frame longer than 63 bytes opens with a 63-byte burst. strobe_tx_o comes in the cycle after its last byte, and the remaining bytes follow in later bursts in address order.
- R5: Each top-up burst is preceded by a status read (stat_rd_o high). In the cycle after the read, burst_start_o is high if fifo_stat_i[7] is 1 or fifo_stat_i[6:0] <= 31, and low otherwise. In the low case the controller waits and reads again.
- R6: Each top-up burst has a size of min(31, bytes remaining). The frame ends when no bytes remain.
- R7: Between two status reads, stat_rd_o stays low for at least poll_gap_i + 1 cycles.
- R8: busy_o is high from the cycle after an accepted start until the final write or transmit-strobe cycle. done_o then pulses for exactly one cycle with busy_o low.
- R9: A status read with fifo_stat_i[7] set makes err_o go high. err_o stays high after the frame ends, and every byte of the frame is still written. The next accepted start clears err_o.
- R10: start_i is ignored while busy_o is high, and also when frame_len_i is 0.
- R11: burst_start_o lasts one cycle with burst_cnt_o non-zero and at most 63. wr_valid_o is then high for exactly burst_cnt_o consecutive cycles starting on the next cycle, and wr_data_o equals buf_data_i at buf_addr_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, sampled in IDLE |
| frame_len_i | input | 8 | Frame length in bytes, latched at start |
| poll_gap_i | input | 8 | Minimum idle cycles between status reads, minus one |
| buf_addr_o | output | 8 | Byte buffer read address |
| buf_data_i | input | 8 | Byte buffer read data, combinational from buf_addr_o |
| fifo_stat_i | input | 8 | Radio FIFO status: [6:0] fill level, [7] underflow |
| stat_rd_o | output | 1 | Status read strobe; fifo_stat_i is sampled in this cycle |
| strobe_idle_o | output | 1 | Idle command strobe to the radio |
| strobe_flush_o | output | 1 | Transmit FIFO flush command strobe |
| strobe_tx_o | output | 1 | Transmit start command strobe |
| burst_start_o | output | 1 | Burst header, one cycle |
| burst_cnt_o | output | 8 | Byte count of the announced burst |
| wr_valid_o | output | 1 | Burst data byte valid |
| wr_data_o | output | 8 | Burst data byte |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle frame completion pulse |
| err_o | output | 1 | Sticky underflow error for the current frame |

## Verification
The assertions treat fifo_stat_i as meaningful only in a stat_rd_o cycle. They take the buffer read port to be combinational, so the byte on wr_data_o belongs to the current address. The bench holds poll_gap_i and the fault setting steady for a whole frame. Its status word comes from a FIFO model that counts written bytes and drains them only after the transmit strobe, at a rate that lets the level fall below the refill threshold. The underflow flag is raised only in the error scenario, and there the model stops draining so that only the flag can release each refill.

// File: rtl/tx_refill_pkg.sv
package tx_refill_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HALT,
        ST_FLUSH,
        ST_HDR,
        ST_DATA,
        ST_FIRE,
        ST_WAIT,
        ST_POLL,
        ST_DONE
    } refill_state_t;

endpackage

// File: rtl/tx_refill_chunk.sv
module tx_refill_chunk #(
    parameter int LEN_W       = 8,
    parameter int FIRST_BURST = 63,
    parameter int CHUNK       = 31
) (
    input  logic             first_i,
    input  logic [LEN_W-1:0] rem_i,
    output logic [LEN_W-1:0] size_o
);
    localparam logic [LEN_W-1:0] FIRST_L = LEN_W'(FIRST_BURST);
    localparam logic [LEN_W-1:0] CHUNK_L = LEN_W'(CHUNK);

    logic [LEN_W-1:0] cap;

    assign cap    = first_i ? FIRST_L : CHUNK_L;
    assign size_o = (rem_i > cap) ? cap : rem_i;
endmodule

// File: rtl/tx_refill_cnt.sv
module tx_refill_cnt #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             chunk_ld_i,
    input  logic [LEN_W-1:0] chunk_i,
    input  logic             step_i,
    output logic [LEN_W-1:0] addr_o,
    output logic [LEN_W-1:0] rem_o,
    output logic [LEN_W-1:0] left_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_o <= '0;
            rem_o  <= '0;
            left_o <= '0;
        end else if (load_i) begin
            addr_o <= '0;
            rem_o  <= len_i;
            left_o <= '0;
        end else if (chunk_ld_i) begin
            left_o <= chunk_i;
        end else if (step_i) begin
            addr_o <= addr_o + 1'b1;
            rem_o  <= rem_o - 1'b1;
            left_o <= left_o - 1'b1;
        end
    end
endmodule

// File: rtl/tx_refill_timer.sv
module tx_refill_timer #(
    parameter int POLL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [POLL_W-1:0] gap_i,
    output logic              zero_o
);
    logic [POLL_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= gap_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/tx_refill_fsm.sv
module tx_refill_fsm
    import tx_refill_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic len_nz_i,
    input  logic left_one_i,
    input  logic rem_one_i,
    input  logic rem_zero_i,
    input  logic gap_zero_i,
    input  logic stat_go_i,
    input  logic stat_uf_i,
    output logic load_o,
    output logic chunk_ld_o,
    output logic step_o,
    output logic timer_ld_o,
    output logic first_o,
    output logic strobe_idle_o,
    output logic strobe_flush_o,
    output logic strobe_tx_o,
    output logic stat_rd_o,
    output logic busy_o,
    output logic done_o,
    output logic err_o
);
    refill_state_t state_q, state_d;
    logic          first_q, err_q;

    assign load_o = (state_q == ST_IDLE) && start_i && len_nz_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q <= 1'b0;
            err_q   <= 1'b0;
        end else if (load_o) begin
            first_q <= 1'b1;
            err_q   <= 1'b0;
        end else begin
            if (state_q == ST_FIRE) first_q <= 1'b0;
            if (state_q == ST_POLL && stat_uf_i) err_q <= 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (load_o) state_d = ST_HALT;
            ST_HALT:  state_d = ST_FLUSH;
            ST_FLUSH: state_d = ST_HDR;
            ST_HDR:   state_d = ST_DATA;
            ST_DATA: begin
                if (left_one_i) begin
                    if (first_q)        state_d = ST_FIRE;
                    else if (rem_one_i) state_d = ST_DONE;
                    else                state_d = ST_WAIT;
                end
            end
            ST_FIRE:  state_d = rem_zero_i ? ST_DONE : ST_WAIT;
            ST_WAIT:  if (gap_zero_i) state_d = ST_POLL;
            ST_POLL:  state_d = stat_go_i ? ST_HDR : ST_WAIT;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        chunk_ld_o     = 1'b0;
        step_o         = 1'b0;
        strobe_idle_o  = 1'b0;
        strobe_flush_o = 1'b0;
        strobe_tx_o    = 1'b0;
        stat_rd_o      = 1'b0;
        done_o         = 1'b0;
        busy_o         = 1'b1;
        unique case (state_q)
            ST_IDLE:  busy_o         = 1'b0;
            ST_HALT:  strobe_idle_o  = 1'b1;
            ST_FLUSH: strobe_flush_o = 1'b1;
            ST_HDR:   chunk_ld_o     = 1'b1;
            ST_DATA:  step_o         = 1'b1;
            ST_FIRE:  strobe_tx_o    = 1'b1;
            ST_WAIT:  ;
            ST_POLL:  stat_rd_o      = 1'b1;
            ST_DONE: begin
                done_o = 1'b1;
                busy_o = 1'b0;
            end
            default:  busy_o = 1'b0;
        endcase
    end

    assign timer_ld_o = (state_d == ST_WAIT) && (state_q != ST_WAIT);
    assign first_o    = first_q;
    assign err_o      = err_q;
endmodule

// File: rtl/tx_refill_ctrl.sv
module tx_refill_ctrl #(
    parameter int LEN_W       = 8,
    parameter int POLL_W      = 8,
    parameter int LEVEL_W     = 7,
    parameter int FIRST_BURST = 63,
    parameter int CHUNK       = 31
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [LEN_W-1:0]   frame_len_i,
    input  logic [POLL_W-1:0]  poll_gap_i,
    output logic [LEN_W-1:0]   buf_addr_o,
    input  logic [7:0]         buf_data_i,
    input  logic [LEVEL_W:0]   fifo_stat_i,
    output logic               stat_rd_o,
    output logic               strobe_idle_o,
    output logic               strobe_flush_o,
    output logic               strobe_tx_o,
    output logic               burst_start_o,
    output logic [LEN_W-1:0]   burst_cnt_o,
    output logic               wr_valid_o,
    output logic [7:0]         wr_data_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               err_o
);
    localparam logic [LEVEL_W-1:0] REFILL_LVL = LEVEL_W'(CHUNK);

    logic             load, chunk_ld, step, timer_ld, first, gap_zero;
    logic             stat_uf, stat_go;
    logic [LEN_W-1:0] rem, left, chunk;

    assign stat_uf = fifo_stat_i[LEVEL_W];
    assign stat_go = stat_uf || (fifo_stat_i[LEVEL_W-1:0] <= REFILL_LVL);

    tx_refill_chunk #(.LEN_W(LEN_W), .FIRST_BURST(FIRST_BURST), .CHUNK(CHUNK)) chunk_i (
        .first_i (first),
        .rem_i   (rem),
        .size_o  (chunk)
    );

    tx_refill_cnt #(.LEN_W(LEN_W)) cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .len_i      (frame_len_i),
        .chunk_ld_i (chunk_ld),
        .chunk_i    (chunk),
        .step_i     (step),
        .addr_o     (buf_addr_o),
        .rem_o      (rem),
        .left_o     (left)
    );

    tx_refill_timer #(.POLL_W(POLL_W)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (timer_ld),
        .gap_i  (poll_gap_i),
        .zero_o (gap_zero)
    );

    tx_refill_fsm fsm_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .len_nz_i       (frame_len_i != '0),
        .left_one_i     (left == LEN_W'(1)),
        .rem_one_i      (rem == LEN_W'(1)),
        .rem_zero_i     (rem == '0),
        .gap_zero_i     (gap_zero),
        .stat_go_i      (stat_go),
        .stat_uf_i      (stat_uf),
        .load_o         (load),
        .chunk_ld_o     (chunk_ld),
        .step_o         (step),
        .timer_ld_o     (timer_ld),
        .first_o        (first),
        .strobe_idle_o  (strobe_idle_o),
        .strobe_flush_o (strobe_flush_o),
        .strobe_tx_o    (strobe_tx_o),
        .stat_rd_o      (stat_rd_o),
        .busy_o         (busy_o),
        .done_o         (done_o),
        .err_o          (err_o)
    );

    assign burst_start_o = chunk_ld;
    assign burst_cnt_o   = chunk;
    assign wr_valid_o    = step;
    assign wr_data_o     = buf_data_i;
endmodule

// File: rtl/tx_refill_chk.sv
module tx_refill_chk #(
    parameter int LEN_W       = 8,
    parameter int LEVEL_W     = 7,
    parameter int FIRST_BURST = 63,
    parameter int CHUNK       = 31
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [LEVEL_W:0] fifo_stat_i,
    input logic             stat_rd_o,
    input logic             strobe_idle_o,
    input logic             strobe_flush_o,
    input logic             strobe_tx_o,
    input logic             burst_start_o,
    input logic [LEN_W-1:0] burst_cnt_o,
    input logic             wr_valid_o,
    input logic             busy_o,
    input logic             done_o,
    input logic             err_o
);
    localparam logic [LEN_W-1:0]   FIRST_L = LEN_W'(FIRST_BURST);
    localparam logic [LEN_W-1:0]   CHUNK_L = LEN_W'(CHUNK);
    localparam logic [LEVEL_W-1:0] LVL_L   = LEVEL_W'(CHUNK);

    assert_flush_follows_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_idle_o |=> strobe_flush_o);
    assert_burst_follows_flush_R2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_flush_o |=> burst_start_o);
    assert_tx_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_tx_o |-> $past(wr_valid_o));
    assert_poll_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_o && !fifo_stat_i[LEVEL_W] && fifo_stat_i[LEVEL_W-1:0] > LVL_L) |=> !burst_start_o);
    assert_poll_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_o && (fifo_stat_i[LEVEL_W] || fifo_stat_i[LEVEL_W-1:0] <= LVL_L)) |=> burst_start_o);
    assert_refill_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_start_o && $past(stat_rd_o)) |-> (burst_cnt_o <= CHUNK_L));
    assert_no_back_to_back_poll_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd_o |=> !stat_rd_o);
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));
    assert_err_clears_on_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_o) |-> strobe_idle_o);
    assert_start_ignored_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> !strobe_idle_o);
    assert_burst_size_R11: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start_o |-> (burst_cnt_o != '0 && burst_cnt_o <= FIRST_L));
    assert_data_follows_hdr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start_o |=> wr_valid_o);
endmodule

bind tx_refill_ctrl tx_refill_chk #(
    .LEN_W(LEN_W), .LEVEL_W(LEVEL_W), .FIRST_BURST(FIRST_BURST), .CHUNK(CHUNK)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .fifo_stat_i    (fifo_stat_i),
    .stat_rd_o      (stat_rd_o),
    .strobe_idle_o  (strobe_idle_o),
    .strobe_flush_o (strobe_flush_o),
    .strobe_tx_o    (strobe_tx_o),
    .burst_start_o  (burst_start_o),
    .burst_cnt_o    (burst_cnt_o),
    .wr_valid_o     (wr_valid_o),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .err_o          (err_o)
);

// File: tb/tx_refill_ctrl_tb_top.sv
`timescale 1ns/1ps
module tx_refill_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] frame_len_i = '0;
    logic [7:0] poll_gap_i = '0;
    logic [7:0] buf_addr_o;
    logic [7:0] buf_data_i;
    logic [7:0] fifo_stat_i;
    logic       stat_rd_o, strobe_idle_o, strobe_flush_o, strobe_tx_o;
    logic       burst_start_o, wr_valid_o, busy_o, done_o, err_o;
    logic [7:0] burst_cnt_o, wr_data_o;

    always #10 clk = ~clk;

    logic [7:0] mem [256];
    assign buf_data_i = mem[buf_addr_o];

    tx_refill_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .frame_len_i(frame_len_i),
        .poll_gap_i(poll_gap_i), .buf_addr_o(buf_addr_o), .buf_data_i(buf_data_i),
        .fifo_stat_i(fifo_stat_i), .stat_rd_o(stat_rd_o), .strobe_idle_o(strobe_idle_o),
        .strobe_flush_o(strobe_flush_o), .strobe_tx_o(strobe_tx_o),
        .burst_start_o(burst_start_o), .burst_cnt_o(burst_cnt_o), .wr_valid_o(wr_valid_o),
        .wr_data_o(wr_data_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // FIFO model and monitor state
    int  level = 0, max_level = 0, drain_div = 0, dcnt = 0;
    bit  tx_on = 0, uf_force = 0;
    int  cyc = 0;
    int  nwr, nb, n_idle, n_flush, n_tx, n_done, npoll, poll_bad;
    int  cyc_idle, cyc_flush, cyc_hdr0, cyc_tx, cyc_last_wr, cyc_wr63, cyc_done;
    int  last_poll, min_sep;
    bit  pend, pend_go, busy_at_done, done_ok;
    logic [7:0] got [256];
    int  bursts [16];

    assign fifo_stat_i = {uf_force, (level > 127) ? 7'd127 : level[6:0]};

    task automatic clear_mon();
        nwr = 0; nb = 0; n_idle = 0; n_flush = 0; n_tx = 0; n_done = 0;
        npoll = 0; poll_bad = 0; cyc_idle = -1; cyc_flush = -1; cyc_hdr0 = -1;
        cyc_tx = -1; cyc_last_wr = -1; cyc_wr63 = -1; cyc_done = -1;
        last_poll = -1; min_sep = 1000000; pend = 0; pend_go = 0;
        busy_at_done = 0; done_ok = 1; max_level = 0;
    endtask

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (pend) begin
            if (burst_start_o !== pend_go) poll_bad = poll_bad + 1;
            pend = 0;
        end
        if (stat_rd_o) begin
            npoll = npoll + 1;
            if (last_poll >= 0 && cyc - last_poll < min_sep) min_sep = cyc - last_poll;
            last_poll = cyc;
            pend = 1;
            pend_go = fifo_stat_i[7] || (fifo_stat_i[6:0] <= 7'd31);
        end
        if (wr_valid_o) begin
            got[nwr[7:0]] = wr_data_o;
            nwr = nwr + 1;
            cyc_last_wr = cyc;
            if (nwr == 63) cyc_wr63 = cyc;
        end
        if (burst_start_o) begin
            if (nb < 16) bursts[nb] = int'(burst_cnt_o);
            if (nb == 0) cyc_hdr0 = cyc;
            nb = nb + 1;
        end
        if (strobe_idle_o)  begin n_idle = n_idle + 1; cyc_idle = cyc; end
        if (strobe_flush_o) begin n_flush = n_flush + 1; cyc_flush = cyc; end
        if (strobe_tx_o)    begin n_tx = n_tx + 1; cyc_tx = cyc; end
        if (done_o) begin
            n_done = n_done + 1; cyc_done = cyc;
            if (busy_o) done_ok = 0;
        end
        // FIFO model
        if (strobe_flush_o) begin
            level = 0; tx_on = 0;
        end else begin
            if (wr_valid_o) level = level + 1;
            if (tx_on && drain_div > 0 && level > 0 && dcnt == 0) level = level - 1;
            if (strobe_tx_o) tx_on = 1;
        end
        if (level > max_level) max_level = level;
        dcnt = (drain_div > 0) ? ((dcnt + 1) % drain_div) : 0;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_start(input int len);
        @(posedge clk); #2;
        frame_len_i = 8'(len);
        start_i = 1'b1;
        @(posedge clk); #2;
        start_i = 1'b0;
    endtask

    task automatic run_frame(input string name, input int len, input int gap,
                             input int drain, input bit uf, input bit poke);
        int exp_b [16];
        int exp_nb, rem, mism, bmism, waited;
        @(posedge clk); #2;
        for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + len * 11 + 5) & 255);
        poll_gap_i = 8'(gap); drain_div = drain; uf_force = uf;
        clear_mon();
        pulse_start(len);
        if (poke) begin
            repeat (20) @(posedge clk);
            #2; frame_len_i = 8'd5; start_i = 1'b1;
            @(posedge clk); #2; start_i = 1'b0;
        end
        waited = 0;
        while (n_done == 0 && waited < 20000) begin
            @(posedge clk); waited++;
        end
        if (n_done == 0) chk({name, " watchdog R8"}, 0, 1);
        repeat (3) @(posedge clk);
        #2;
        exp_nb = 0;
        rem = len;
        exp_b[exp_nb++] = (rem > 63) ? 63 : rem;
        rem = rem - exp_b[0];
        while (rem > 0) begin
            exp_b[exp_nb] = (rem > 31) ? 31 : rem;
            rem = rem - exp_b[exp_nb];
            exp_nb++;
        end
        mism = 0;
        for (int i = 0; i < len; i++) if (got[i] !== mem[i]) mism++;
        bmism = 0;
        for (int i = 0; i < exp_nb && i < nb; i++) if (bursts[i] != exp_b[i]) bmism++;
        chk({name, " R11 byte count"}, nwr, len);
        chk({name, " R11 data order"}, mism, 0);
        chk({name, " R6 burst count"}, nb, exp_nb);
        chk({name, " R6 burst sizes"}, bmism, 0);
        chk({name, " R2 idle strobe"}, n_idle, 1);
        chk({name, " R2 flush next"}, cyc_flush - cyc_idle, 1);
        chk({name, " R2 header next"}, cyc_hdr0 - cyc_flush, 1);
        chk({name, " R10 one tx strobe"}, n_tx, 1);
        chk({name, " R8 one done"}, n_done, 1);
        chk({name, " R8 busy low at done"}, int'(done_ok), 1);
        chk({name, " R8 busy after"}, int'(busy_o), 0);
        chk({name, " R9 err flag"}, int'(err_o), int'(uf && len > 63));
        if (len <= 63) begin
            chk({name, " R3 tx after last"}, cyc_tx - cyc_last_wr, 1);
            chk({name, " R3 no polls"}, npoll, 0);
            chk({name, " R8 done after tx"}, cyc_done - cyc_tx, 1);
        end else begin
            chk({name, " R4 tx after 63"}, cyc_tx - cyc_wr63, 1);
            chk({name, " R8 done after last"}, cyc_done - cyc_last_wr, 1);
            chk({name, " R5 poll gating"}, poll_bad, 0);
            chk({name, " R5 polls seen"}, int'(npoll >= exp_nb - 1), 1);
            if (npoll > 1) chk({name, " R7 poll spacing"}, int'(min_sep >= gap + 2), 1);
            if (!uf) chk({name, " R5 no overflow"}, int'(max_level <= 63), 1);
        end
    endtask

    task automatic test_reset();
        chk("R1 busy", int'(busy_o), 0);
        chk("R1 done", int'(done_o), 0);
        chk("R1 err", int'(err_o), 0);
        chk("R1 wr_valid", int'(wr_valid_o), 0);
        chk("R1 stat_rd", int'(stat_rd_o), 0);
        chk("R1 strobes", int'({strobe_idle_o, strobe_flush_o, strobe_tx_o}), 0);
    endtask

    task automatic test_zero_len();
        clear_mon();
        pulse_start(0);
        repeat (8) @(posedge clk);
        #2;
        chk("R10 zero len no strobe", n_idle, 0);
        chk("R10 zero len not busy", int'(busy_o), 0);
        chk("R10 zero len no write", nwr, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        test_reset();
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #2;
        test_reset();
        test_zero_len();
        run_frame("short20", 20, 0, 2, 0, 0);
        run_frame("edge63", 63, 1, 2, 0, 0);
        run_frame("edge64", 64, 2, 2, 0, 0);
        run_frame("long200", 200, 0, 2, 0, 0);
        run_frame("gap5", 150, 5, 3, 0, 0);
        run_frame("busy_poke", 200, 3, 2, 0, 1);
        run_frame("underflow", 100, 1, 0, 1, 0);
        chk("R9 err sticky after frame", int'(err_o), 1);
        run_frame("after_err", 10, 0, 2, 0, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog R8: actual 0 expected 1");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule